// File: doc/BRIEF.md
# Power-Management Configuration Window Decoder

This block is the configuration-register front end of a power-management function in a south-bridge-style peripheral. Software reaches it through a byte-wide read/write port. The port holds two general configuration bytes, a 16-bit base register for a 128-byte power-management I/O window, and a matching base register and control byte for a 16-byte SMBus controller window. The block does not contain the registers inside those windows.

Every I/O-space address on `io_addr` is compared against both bases. Each window gives a hit flag and the low offset bits. The window registers sit beside this block and use these flags to claim the cycle. Decoding is gated by an enable bit that lives in a different configuration byte.

Any configuration access to an offset with no register drives a one-cycle debug pulse. Every reset, not only the first, restores all registers to their defaults, and the decode follows from those defaults at once.

Top module: `pm_cfg_window`

## Requirements
- R1: After reset, reads return 0x00 at offsets 0x40, 0x41, 0x49, 0x91 and 0xD2, and 0x01 at offsets 0x48 and 0x90. With these defaults neither window hits.
- R2: The power-management base is {offset 0x49, offset 0x48}. Bit 0 always reads 1 and bits 6:1 always read 0 whatever is written. Bit 7 and the whole of offset 0x49 are writable (writable mask 0xFF80).
- R3: While bit 7 of offset 0x41 is 1, `pm_hit` is 1 exactly when io_addr[15:7] equals base[15:7], and `pm_off` then equals io_addr[6:0].
- R4: While bit 7 of offset 0x41 is 0, `pm_hit` is 0 for every address and `pm_off` is 0.
- R5: The SMBus base is {offset 0x91, offset 0x90}, with writable mask 0xFFF0 and bit 0 reading 1. `smb_hit` is 1 exactly when bit 0 of offset 0xD2 is 1 and io_addr[15:4] equals base[15:4]; `smb_off` is then io_addr[3:0], and 0 when there is no hit.
- R6: A write to a base byte or an enable byte changes the decode from the clock edge that captures the write, so the new decode is visible in the following cycle.
- R7: A read or write to any offset other than the seven listed in R1 pulses `cfg_unimpl` high for exactly the cycle after the access. Such a write changes no register, and such a read returns 0x00. Accesses to listed offsets, and idle cycles, leave `cfg_unimpl` low.
- R8: `cfg_rdata` is registered. It shows the addressed byte in the cycle after `cfg_re` and holds that value while no read is made.
- R9: A reset asserted during operation returns every register to its R1 default, and the window decode follows those defaults at once.
- R10: With the power-management enable set and the base at its default, addresses 0x0000 to 0x007F hit and 0x0080 misses.
- R11: Offsets 0x40, 0x41 and 0xD2 are fully writable bytes that read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered configuration read data |
| cfg_unimpl | output | 1 | One-cycle pulse after an access to an offset with no register |
| io_addr | input | 16 | I/O-space address to decode |
| pm_hit | output | 1 | Address falls in the enabled power-management window |
| pm_off | output | 7 | Offset inside the power-management window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window |
| smb_off | output | 4 | Offset inside the SMBus window |

## Verification
The hardest situation to reach from the ports is a window that has moved away from its default base and sits right next to a mask boundary. Reaching it needs several ordered writes: both base bytes, including a low byte whose masked bits must be dropped, and then the enable byte. Directed sequences build such bases and probe the addresses one below, at, and at the top of each window. Constrained-random writes to the implemented offsets then keep moving the bases and enables, with decode probes clustered around the current bases. A reset in the middle of the run shows that the decode collapses back to its defaults.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;
    // Register state of the configuration block, one byte per implemented offset
    typedef struct packed {
        logic [7:0] gen0;
        logic [7:0] gen1;
        logic [7:0] pm_lo;
        logic [7:0] pm_hi;
        logic [7:0] smb_lo;
        logic [7:0] smb_hi;
        logic [7:0] smb_ctl;
        logic [7:0] rdata;
        logic       unimpl;
    } cfg_state_t;

    localparam logic [7:0] BASE_LSB_FORCE = 8'h01;
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_cfg_pkg::*;
#(
    parameter int         IOW          = 16,
    parameter int         PM_WIN_LOG2  = 7,
    parameter int         SMB_WIN_LOG2 = 4,
    parameter int         PM_EN_BIT    = 7,
    parameter int         SMB_EN_BIT   = 0,
    parameter logic [7:0] OFF_GEN0     = 8'h40,
    parameter logic [7:0] OFF_GEN1     = 8'h41,
    parameter logic [7:0] OFF_PM_LO    = 8'h48,
    parameter logic [7:0] OFF_PM_HI    = 8'h49,
    parameter logic [7:0] OFF_SMB_LO   = 8'h90,
    parameter logic [7:0] OFF_SMB_HI   = 8'h91,
    parameter logic [7:0] OFF_SMB_CTL  = 8'hD2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_re,
    input  logic [7:0]     cfg_addr,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    output logic           cfg_unimpl,
    output logic [IOW-1:0] pm_base,
    output logic           pm_en,
    output logic [IOW-1:0] smb_base,
    output logic           smb_en
);
    localparam logic [IOW-1:0] PM_WMASK  = {IOW{1'b1}} << PM_WIN_LOG2;
    localparam logic [IOW-1:0] SMB_WMASK = {IOW{1'b1}} << SMB_WIN_LOG2;
    localparam logic [7:0]     PM_LO_WM  = PM_WMASK[7:0];
    localparam logic [7:0]     SMB_LO_WM = SMB_WMASK[7:0];

    localparam cfg_state_t RESET_STATE = '{
        gen0: 8'h00, gen1: 8'h00,
        pm_lo: BASE_LSB_FORCE, pm_hi: 8'h00,
        smb_lo: BASE_LSB_FORCE, smb_hi: 8'h00,
        smb_ctl: 8'h00, rdata: 8'h00, unimpl: 1'b0
    };

    cfg_state_t s_d, s_q;
    logic [7:0] rd_val;
    logic       is_impl;

    always_comb begin
        is_impl = 1'b1;
        rd_val  = 8'h00;
        case (cfg_addr)
            OFF_GEN0:    rd_val = s_q.gen0;
            OFF_GEN1:    rd_val = s_q.gen1;
            OFF_PM_LO:   rd_val = s_q.pm_lo;
            OFF_PM_HI:   rd_val = s_q.pm_hi;
            OFF_SMB_LO:  rd_val = s_q.smb_lo;
            OFF_SMB_HI:  rd_val = s_q.smb_hi;
            OFF_SMB_CTL: rd_val = s_q.smb_ctl;
            default:     is_impl = 1'b0;
        endcase

        s_d        = s_q;
        s_d.unimpl = (cfg_we || cfg_re) && !is_impl;
        if (cfg_re) begin
            s_d.rdata = rd_val;
        end
        if (cfg_we) begin
            case (cfg_addr)
                OFF_GEN0:    s_d.gen0    = cfg_wdata;
                OFF_GEN1:    s_d.gen1    = cfg_wdata;
                OFF_PM_LO:   s_d.pm_lo   = (cfg_wdata & PM_LO_WM) | BASE_LSB_FORCE;
                OFF_PM_HI:   s_d.pm_hi   = cfg_wdata & PM_WMASK[15:8];
                OFF_SMB_LO:  s_d.smb_lo  = (cfg_wdata & SMB_LO_WM) | BASE_LSB_FORCE;
                OFF_SMB_HI:  s_d.smb_hi  = cfg_wdata & SMB_WMASK[15:8];
                OFF_SMB_CTL: s_d.smb_ctl = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RESET_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_rdata  = s_q.rdata;
    assign cfg_unimpl = s_q.unimpl;
    assign pm_base    = {s_q.pm_hi, s_q.pm_lo};
    assign smb_base   = {s_q.smb_hi, s_q.smb_lo};
    assign pm_en      = s_q.gen1[PM_EN_BIT];
    assign smb_en     = s_q.smb_ctl[SMB_EN_BIT];
endmodule

// File: rtl/io_win_dec.sv
module io_win_dec #(
    parameter int IOW      = 16,
    parameter int WIN_LOG2 = 7
) (
    input  logic [IOW-1:0]      io_addr,
    input  logic [IOW-1:0]      base,
    input  logic                en,
    output logic                hit,
    output logic [WIN_LOG2-1:0] off
);
    always_comb begin
        hit = en && (io_addr[IOW-1:WIN_LOG2] == base[IOW-1:WIN_LOG2]);
        off = hit ? io_addr[WIN_LOG2-1:0] : '0;
    end
endmodule

// File: rtl/pm_cfg_window.sv
module pm_cfg_window #(
    parameter int IOW          = 16,
    parameter int PM_WIN_LOG2  = 7,
    parameter int SMB_WIN_LOG2 = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic                    cfg_re,
    input  logic [7:0]              cfg_addr,
    input  logic [7:0]              cfg_wdata,
    output logic [7:0]              cfg_rdata,
    output logic                    cfg_unimpl,
    input  logic [IOW-1:0]          io_addr,
    output logic                    pm_hit,
    output logic [PM_WIN_LOG2-1:0]  pm_off,
    output logic                    smb_hit,
    output logic [SMB_WIN_LOG2-1:0] smb_off
);
    logic [IOW-1:0] pm_base, smb_base;
    logic           pm_en, smb_en;

    pm_cfg_regs #(
        .IOW(IOW), .PM_WIN_LOG2(PM_WIN_LOG2), .SMB_WIN_LOG2(SMB_WIN_LOG2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_unimpl(cfg_unimpl),
        .pm_base(pm_base), .pm_en(pm_en), .smb_base(smb_base), .smb_en(smb_en)
    );

    io_win_dec #(.IOW(IOW), .WIN_LOG2(PM_WIN_LOG2)) u_pm_dec (
        .io_addr(io_addr), .base(pm_base), .en(pm_en), .hit(pm_hit), .off(pm_off)
    );

    io_win_dec #(.IOW(IOW), .WIN_LOG2(SMB_WIN_LOG2)) u_smb_dec (
        .io_addr(io_addr), .base(smb_base), .en(smb_en), .hit(smb_hit), .off(smb_off)
    );
endmodule

// File: rtl/pm_cfg_window_chk.sv
module pm_cfg_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic        cfg_re,
    input logic [7:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic        cfg_unimpl,
    input logic [15:0] io_addr,
    input logic        pm_hit,
    input logic        smb_hit,
    input logic [15:0] pm_base,
    input logic        pm_en,
    input logic [15:0] smb_base,
    input logic        smb_en
);
    logic listed;
    assign listed = (cfg_addr == 8'h40) || (cfg_addr == 8'h41) || (cfg_addr == 8'h48) ||
                    (cfg_addr == 8'h49) || (cfg_addr == 8'h90) || (cfg_addr == 8'h91) ||
                    (cfg_addr == 8'hD2);

    AST_UNIMPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_we || cfg_re) && !listed) |=> cfg_unimpl); // R7
    AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_we || cfg_re) || listed) |=> !cfg_unimpl); // R7
    AST_PM_BIT0_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pm_base[0] && smb_base[0]); // R2
    AST_PM_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pm_base[6:1] == 6'd0); // R2
    AST_PM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_en |-> !pm_hit); // R4
    AST_PM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pm_hit |-> (io_addr[15:7] == pm_base[15:7])); // R3
    AST_SMB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> (smb_en && io_addr[15:4] == smb_base[15:4])); // R5
    AST_EN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h41) |=> (pm_en == $past(cfg_wdata[7]))); // R6
endmodule

bind pm_cfg_window pm_cfg_window_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_unimpl(cfg_unimpl),
    .io_addr(io_addr), .pm_hit(pm_hit), .smb_hit(smb_hit),
    .pm_base(pm_base), .pm_en(pm_en), .smb_base(smb_base), .smb_en(smb_en)
);

// File: tb/sim_pm_cfg_window.sv
module sim_pm_cfg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_re = 1'b0;
    logic [7:0]  cfg_addr = 8'h00, cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        cfg_unimpl;
    logic [15:0] io_addr = 16'h0000;
    logic        pm_hit, smb_hit;
    logic [6:0]  pm_off;
    logic [3:0]  smb_off;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] mdl [256];

    always #2.5 clk = ~clk;

    pm_cfg_window u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_unimpl(cfg_unimpl), .io_addr(io_addr), .pm_hit(pm_hit), .pm_off(pm_off),
        .smb_hit(smb_hit), .smb_off(smb_off)
    );

    function automatic bit is_listed(input logic [7:0] a);
        return a == 8'h40 || a == 8'h41 || a == 8'h48 || a == 8'h49 ||
               a == 8'h90 || a == 8'h91 || a == 8'hD2;
    endfunction

    function automatic logic [7:0] stored(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h48) return (d & 8'h80) | 8'h01;
        if (a == 8'h90) return (d & 8'hF0) | 8'h01;
        return d;
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        mdl[8'h48] = 8'h01;
        mdl[8'h90] = 8'h01;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // All tasks start just after a falling edge.
    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        check("R7", "unimpl after write", {31'd0, cfg_unimpl}, {31'd0, !is_listed(a)});
        if (is_listed(a)) mdl[a] = stored(a, d);
    endtask

    task automatic do_read(input string req, input logic [7:0] a);
        cfg_addr = a; cfg_re = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_re = 1'b0;
        check(req, "read data", {24'd0, cfg_rdata}, {24'd0, mdl[a]});
        check("R7", "unimpl after read", {31'd0, cfg_unimpl}, {31'd0, !is_listed(a)});
    endtask

    task automatic chk_win(input string req, input logic [15:0] a);
        logic [15:0] pb, sb;
        logic ph, sh;
        pb = {mdl[8'h49], mdl[8'h48]};
        sb = {mdl[8'h91], mdl[8'h90]};
        ph = mdl[8'h41][7] && (a[15:7] == pb[15:7]);
        sh = mdl[8'hD2][0] && (a[15:4] == sb[15:4]);
        io_addr = a;
        #0.5;
        check(req, "pm_hit", {31'd0, pm_hit}, {31'd0, ph});
        check(req, "pm_off", {25'd0, pm_off}, ph ? {25'd0, a[6:0]} : 32'd0);
        check(req, "smb_hit", {31'd0, smb_hit}, {31'd0, sh});
        check(req, "smb_off", {28'd0, smb_off}, sh ? {28'd0, a[3:0]} : 32'd0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mdl_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 50000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] lst [7];
        lst = '{8'h40, 8'h41, 8'h48, 8'h49, 8'h90, 8'h91, 8'hD2};
        void'($urandom(32'd1234));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "unimpl idle", {31'd0, cfg_unimpl}, 32'd0);
        foreach (lst[i]) do_read("R1", lst[i]);
        chk_win("R1", 16'h0000);
        chk_win("R1", 16'h0001);

        // R10 default base, enable on
        do_write(8'h41, 8'h80);
        chk_win("R10", 16'h0000);
        chk_win("R10", 16'h007F);
        chk_win("R10", 16'h0080);
        check("R10", "edge hit", {31'd0, pm_hit}, 32'd0);

        // R2 masking, R3 and R6 moved window
        do_write(8'h48, 8'h34);
        do_read("R2", 8'h48);
        check("R2", "lo masked", {24'd0, cfg_rdata}, 32'h01);
        do_write(8'h49, 8'h12);
        chk_win("R6", 16'h1200);
        do_write(8'h48, 8'hFF);
        do_read("R2", 8'h48);
        check("R2", "lo bit7", {24'd0, cfg_rdata}, 32'h81);
        chk_win("R3", 16'h127F);
        chk_win("R3", 16'h1280);
        chk_win("R3", 16'h12FF);
        chk_win("R3", 16'h1300);
        check("R3", "top offset", {25'd0, pm_off}, 32'd0);

        // R4 disable
        do_write(8'h41, 8'h7F);
        chk_win("R4", 16'h1290);
        check("R4", "disabled", {31'd0, pm_hit}, 32'd0);
        do_read("R11", 8'h41);

        // R5 SMBus window
        do_write(8'h90, 8'hAB);
        do_write(8'h91, 8'h5C);
        do_read("R5", 8'h90);
        chk_win("R5", 16'h5CA3);
        do_write(8'hD2, 8'h01);
        chk_win("R5", 16'h5CA0);
        chk_win("R5", 16'h5CAF);
        chk_win("R5", 16'h5CB0);
        chk_win("R5", 16'h5C9F);

        // R7 unimplemented offsets, R8 hold, R11 full bytes
        do_write(8'h40, 8'hC3);
        do_read("R11", 8'h40);
        do_write(8'h42, 8'hFF);
        do_read("R7", 8'h42);
        do_write(8'h4A, 8'h55);
        do_read("R7", 8'h49);
        @(negedge clk);
        check("R7", "pulse ends", {31'd0, cfg_unimpl}, 32'd0);
        check("R8", "rdata holds", {24'd0, cfg_rdata}, {24'd0, mdl[8'h49]});

        // R9 reset during operation
        do_write(8'h41, 8'h80);
        apply_reset();
        chk_win("R9", 16'h1280);
        chk_win("R9", 16'h0010);
        foreach (lst[i]) do_read("R9", lst[i]);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [7:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            a = (sel < 7) ? lst[sel] : 8'($urandom);
            case ($urandom_range(0, 2))
                0: do_write(a, 8'($urandom));
                1: do_read("R8", a);
                default: ;
            endcase
            sel = $urandom_range(0, 2);
            if (sel == 0)
                chk_win("R3", {mdl[8'h49], mdl[8'h48]} + 16'($urandom_range(0, 255)) - 16'd64);
            else if (sel == 1)
                chk_win("R5", {mdl[8'h91], mdl[8'h90]} + 16'($urandom_range(0, 47)) - 16'd16);
            else
                chk_win("R3", 16'($urandom));
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule